// File: doc/BRIEF.md
# Multi-Bank Pad Configuration Register Block

This block holds the electrical and function settings for the pads of several banks, each bank having up to 32 pins. Software reaches it through a simple word-addressed register port: every bank owns a window of 64 words (0x100 bytes), and bank `b` starts at word `b*64`. Each pin gets a function-select value, pull-up and pull-down enables, an open-drain enable, a slew-rate control bit and a 2-bit drive-strength code. The settings leave the block as flat per-pin vectors that drive the pad ring.

Not every bank has all 32 pins. A build-time mask marks which pins exist. Software can read this mask, and the block discards any write aimed at a missing pin. Within a bank, the word offset of a register is the byte offset divided by 4. The function selects sit at offsets 0 to 31, one word per pin. Pull-up is at 32, pull-down at 33, open-drain at 34, slew at 35, drive for pins 0 to 15 at 36, drive for pins 16 to 31 at 37, and the read-only availability mask at 38.

Top module: `pad_cfg_bank_regs`

## Requirements
- R1: After reset every configuration register and every pad output is zero: GPIO function, no pulls, push-pull, lowest drive and slew. Offset 38 of each bank reads that bank's availability mask.
- R2: Bank `b` decodes word addresses `b*64` to `b*64+63`. A write to a bank index at or above NBANKS changes nothing, and a read from it returns zero.
- R3: The function select of pin `p` is the word at offset `p`. A write stores the low FSEL_W bits of the data. A read returns the stored value zero-extended. Output `pad_func` carries pin `b*32+p` in bits `(b*32+p)*FSEL_W +: FSEL_W`. The value 0 means GPIO.
- R4: A write to the function select of a pin whose availability bit is clear is discarded, and that register reads as zero.
- R5: The one-bit-per-pin registers use bit `p` for pin `p`: pull-up at offset 32, pull-down at 33, open-drain at 34 and slew at 35. Bits of missing pins are not written and read as zero. `pad_pu`, `pad_od` and `pad_slew` carry pin `b*32+p` at bit `b*32+p`.
- R6: The drive code of pin `p` is in the word at offset `36 + p/16`, bits `2*(p%16)+1 : 2*(p%16)`. A missing pin's field is not written and reads as zero. `pad_drv` carries pin `b*32+p` in bits `2*(b*32+p) +: 2`.
- R7: If pull-up and pull-down are both set for a pin, `pad_pd` for that pin is 0 while `pad_pu` is 1. The pull-down register still reads back its stored bit.
- R8: The availability word at offset 38 is read-only. Writes to it do not change its value or any output.
- R9: Offsets 39 to 63 read as zero, and writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Word address: bank index in the upper bits, offset in the low 6 bits |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pad_func | output | NBANKS*32*FSEL_W | Function select per pin |
| pad_pu | output | NBANKS*32 | Pull-up enable per pin |
| pad_pd | output | NBANKS*32 | Pull-down enable per pin, after pull-up priority |
| pad_od | output | NBANKS*32 | Open-drain enable per pin |
| pad_slew | output | NBANKS*32 | Slew-rate control per pin |
| pad_drv | output | NBANKS*64 | 2-bit drive code per pin |

## Verification
The bench uses three banks with sparse, irregular availability masks and sweeps every pin of every bank through every register. A design that ignored the mask would show the junk written to missing pins on the pads and in read-back. A design that took the wrong bits of a packed drive word would put drive codes on the neighbouring pins. The bench sets pull-up and pull-down together on a fully populated bank, where a missing priority shows up as both pulls active on one pad. It also targets a bank index beyond the last bank, the read-only mask word and the unused offsets. Faulty address decoding in any of these cases would corrupt a real bank's settings.

// File: rtl/pad_cfg_bank_regs.sv
module pad_cfg_bank_regs #(
  parameter int NBANKS = 2,
  parameter int FSEL_W = 4,
  parameter logic [NBANKS*32-1:0] AVAIL = '1,
  localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int ADDR_W = BW + 6,
  localparam int NPINS = NBANKS * 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [NPINS*FSEL_W-1:0] pad_func,
  output logic [NPINS-1:0]        pad_pu,
  output logic [NPINS-1:0]        pad_pd,
  output logic [NPINS-1:0]        pad_od,
  output logic [NPINS-1:0]        pad_slew,
  output logic [NPINS*2-1:0]      pad_drv
);

  localparam logic [5:0] OFF_PU    = 6'd32;
  localparam logic [5:0] OFF_PD    = 6'd33;
  localparam logic [5:0] OFF_OD    = 6'd34;
  localparam logic [5:0] OFF_SLEW  = 6'd35;
  localparam logic [5:0] OFF_DRV0  = 6'd36;
  localparam logic [5:0] OFF_DRV1  = 6'd37;
  localparam logic [5:0] OFF_AVAIL = 6'd38;

  logic [BW-1:0] bank_idx;
  logic [5:0]    off;
  logic          bank_ok;
  logic          sel_avail;
  logic [NBANKS-1:0] bank_hit;

  logic [FSEL_W-1:0] fsel [NPINS];
  logic [31:0] pu   [NBANKS];
  logic [31:0] pd   [NBANKS];
  logic [31:0] od   [NBANKS];
  logic [31:0] slew [NBANKS];
  logic [63:0] drv  [NBANKS];
  logic [31:0] avail [NBANKS];
  logic [63:0] dmask [NBANKS];

  assign bank_idx = addr[ADDR_W-1:6];
  assign off      = addr[5:0];
  assign bank_ok  = int'(bank_idx) < NBANKS;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign avail[b]    = AVAIL[b*32 +: 32];
    assign bank_hit[b] = we && bank_ok && (bank_idx == BW'(b));
    for (genvar p = 0; p < 32; p++) begin : g_pin
      assign dmask[b][2*p +: 2] = {2{AVAIL[b*32+p]}};
      assign pad_func[(b*32+p)*FSEL_W +: FSEL_W] = fsel[b*32+p];
    end
    assign pad_pu[b*32 +: 32]   = pu[b];
    assign pad_pd[b*32 +: 32]   = pd[b] & ~pu[b];
    assign pad_od[b*32 +: 32]   = od[b];
    assign pad_slew[b*32 +: 32] = slew[b];
    assign pad_drv[b*64 +: 64]  = drv[b];
  end

  always_comb begin
    sel_avail = 1'b0;
    for (int b = 0; b < NBANKS; b++)
      if (bank_ok && bank_idx == BW'(b))
        sel_avail = avail[b][off[4:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) fsel[i] <= '0;
      for (int b = 0; b < NBANKS; b++) begin
        pu[b]   <= '0;
        pd[b]   <= '0;
        od[b]   <= '0;
        slew[b] <= '0;
        drv[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (bank_hit[b]) begin
          if (!off[5] && avail[b][off[4:0]])
            fsel[b*32 + int'(off[4:0])] <= wdata[FSEL_W-1:0];
          case (off)
            OFF_PU:   pu[b]         <= wdata & avail[b];
            OFF_PD:   pd[b]         <= wdata & avail[b];
            OFF_OD:   od[b]         <= wdata & avail[b];
            OFF_SLEW: slew[b]       <= wdata & avail[b];
            OFF_DRV0: drv[b][31:0]  <= wdata & dmask[b][31:0];
            OFF_DRV1: drv[b][63:32] <= wdata & dmask[b][63:32];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_ok && bank_idx == BW'(b)) begin
        if (!off[5]) rdata = 32'(fsel[b*32 + int'(off[4:0])]);
        else begin
          case (off)
            OFF_PU:    rdata = pu[b];
            OFF_PD:    rdata = pd[b];
            OFF_OD:    rdata = od[b];
            OFF_SLEW:  rdata = slew[b];
            OFF_DRV0:  rdata = drv[b][31:0];
            OFF_DRV1:  rdata = drv[b][63:32];
            OFF_AVAIL: rdata = avail[b];
            default:   rdata = '0;
          endcase
        end
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_func == '0 && pad_pu == '0 && pad_pd == '0 &&
                      pad_od == '0 && pad_slew == '0 && pad_drv == '0)); // R1

  AST_OOB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !bank_ok) |=> ($stable(pad_func) && $stable(pad_pu) && $stable(pad_pd) &&
                          $stable(pad_od) && $stable(pad_slew) && $stable(pad_drv))); // R2

  AST_ABSENT_FSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bank_ok && !off[5] && !sel_avail) |=> $stable(pad_func)); // R4

  AST_PULL_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0); // R7

  AST_AVAIL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == OFF_AVAIL) |=> ($stable(pad_func) && $stable(pad_pu) && $stable(pad_pd) &&
                                  $stable(pad_od) && $stable(pad_slew) && $stable(pad_drv))); // R8

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off > OFF_AVAIL) |=> ($stable(pad_func) && $stable(pad_pu) && $stable(pad_pd) &&
                                 $stable(pad_od) && $stable(pad_slew) && $stable(pad_drv))); // R9

endmodule

// File: tb/test_pad_cfg_bank_regs.sv
`timescale 1ns/1ps
module test_pad_cfg_bank_regs;
  localparam int NB = 3;
  localparam int FW = 4;
  localparam int AW = 8;
  localparam int NP = NB * 32;
  localparam logic [NB*32-1:0] MASKS = {32'hA5A5_0001, 32'h0F0F_33C5, 32'hFFFF_FFFF};

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP*FW-1:0] pad_func;
  logic [NP-1:0] pad_pu, pad_pd, pad_od, pad_slew;
  logic [NP*2-1:0] pad_drv;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pad_cfg_bank_regs #(.NBANKS(NB), .FSEL_W(FW), .AVAIL(MASKS)) i_pad_cfg_bank_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_func(pad_func), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od),
    .pad_slew(pad_slew), .pad_drv(pad_drv));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int b, int o, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = AW'(b*64 + o); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int b, int o, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(b*64 + o);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] mask(int b);
    return MASKS[b*32 +: 32];
  endfunction

  function automatic logic [3:0] fval(int b, int p);
    return 4'((b*5 + p*3 + 1) % 16);
  endfunction

  function automatic logic [31:0] pat(int b, int r);
    return 32'(32'h9E37_79B9 * (b*8 + r + 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP*FW-1:0] sf;
    logic [NP-1:0] spu, spd, sod, ssl;
    logic [NP*2-1:0] sdr;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 func", 64'(pad_func), 0);
    check("R1 pu", 64'(pad_pu), 0);
    check("R1 pd", 64'(pad_pd), 0);
    check("R1 od", 64'(pad_od), 0);
    check("R1 slew", 64'(pad_slew), 0);
    check("R1 drv", 64'(pad_drv), 0);
    for (int b = 0; b < NB; b++) begin
      rd(b, 38, d); check("R1 avail read", 64'(d), 64'(mask(b)));
    end

    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 32; p++)
        wr(b, p, 32'hFFFF_FFF0 | 32'(fval(b, p)));
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 32; p++) begin
        logic [3:0] e;
        e = mask(b)[p] ? fval(b, p) : 4'd0;
        rd(b, p, d);
        check(mask(b)[p] ? "R3 fsel read" : "R4 absent fsel read", 64'(d), 64'(e));
        check(mask(b)[p] ? "R3 pad_func" : "R4 absent pad_func",
              64'(pad_func[(b*32+p)*FW +: FW]), 64'(e));
      end
    wr(0, 5, 32'h0);
    check("R3 gpio select", 64'(pad_func[5*FW +: FW]), 0);

    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < 4; r++) wr(b, 32 + r, pat(b, r));
      for (int r = 0; r < 4; r++) begin
        rd(b, 32 + r, d);
        check("R5 bit reg read", 64'(d), 64'(pat(b, r) & mask(b)));
      end
      check("R5 pad_pu", 64'(pad_pu[b*32 +: 32]), 64'(pat(b, 0) & mask(b)));
      check("R5 pad_od", 64'(pad_od[b*32 +: 32]), 64'(pat(b, 2) & mask(b)));
      check("R5 pad_slew", 64'(pad_slew[b*32 +: 32]), 64'(pat(b, 3) & mask(b)));
      check("R7 pad_pd priority", 64'(pad_pd[b*32 +: 32]),
            64'(pat(b, 1) & mask(b) & ~pat(b, 0)));
    end
    wr(0, 32, 32'hFFFF_FFFF);
    wr(0, 33, 32'hFFFF_FFFF);
    check("R7 both set pd", 64'(pad_pd[31:0]), 0);
    check("R7 both set pu", 64'(pad_pu[31:0]), 64'hFFFF_FFFF);
    rd(0, 33, d);
    check("R7 pd readback", 64'(d), 64'hFFFF_FFFF);

    for (int b = 0; b < NB; b++) begin
      logic [63:0] dw;
      dw = {pat(b, 5), pat(b, 4)};
      wr(b, 36, dw[31:0]);
      wr(b, 37, dw[63:32]);
      for (int p = 0; p < 32; p++)
        check("R6 drive field", 64'(pad_drv[(b*32+p)*2 +: 2]),
              mask(b)[p] ? 64'(dw[2*p +: 2]) : 64'd0);
      rd(b, 37, d);
      begin
        logic [31:0] em;
        for (int q = 0; q < 16; q++) em[2*q +: 2] = {2{mask(b)[16+q]}};
        check("R6 drive hi read", 64'(d), 64'(dw[63:32] & em));
      end
    end

    sf = pad_func; spu = pad_pu; spd = pad_pd; sod = pad_od; ssl = pad_slew; sdr = pad_drv;
    wr(3, 0, 32'h7); wr(3, 32, 32'hFFFF_FFFF); wr(3, 37, 32'hFFFF_FFFF);
    rd(3, 0, d); check("R2 oob read fsel", 64'(d), 0);
    rd(3, 32, d); check("R2 oob read pu", 64'(d), 0);
    rd(3, 38, d); check("R2 oob read avail", 64'(d), 0);
    wr(1, 38, 32'h0); wr(2, 38, 32'hFFFF_FFFF);
    rd(1, 38, d); check("R8 avail ro", 64'(d), 64'(mask(1)));
    rd(2, 38, d); check("R8 avail ro", 64'(d), 64'(mask(2)));
    wr(0, 39, 32'hFFFF_FFFF); wr(1, 63, 32'hFFFF_FFFF);
    rd(0, 39, d); check("R9 unused read", 64'(d), 0);
    rd(1, 63, d); check("R9 unused read", 64'(d), 0);
    check("R2 R8 R9 func stable", 64'(sf != pad_func), 0);
    check("R2 R8 R9 pu stable", 64'(spu != pad_pu), 0);
    check("R2 R8 R9 pd stable", 64'(spd != pad_pd), 0);
    check("R2 R8 R9 od stable", 64'(sod != pad_od), 0);
    check("R2 R8 R9 slew stable", 64'(ssl != pad_slew), 0);
    check("R2 R8 R9 drv stable", 64'(sdr != pad_drv), 0);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 rereset func", 64'(pad_func != '0), 0);
    check("R1 rereset drv", 64'(pad_drv != '0), 0);
    check("R1 rereset pu", 64'(pad_pu != '0), 0);
    rst_n = 1;
    rd(2, 0, d); check("R1 rereset fsel read", 64'(d), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule